// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter

This block turns a stream of 16-bit audio samples into a two-slot serial audio frame on one data line. Each frame carries a bit clock and a frame (left/right) clock. The frame can use standard I2S timing, left-justified timing or right-justified timing. Either clock can be inverted on its own. The block can drive both clocks itself from a bit-clock enable supplied by a divider. It can also run as a clock follower: it oversamples an external bit clock and frame clock in its own clock domain and aligns its frame to the external frame clock.

Samples enter through a valid/ready handshake and are collected into a small holding buffer. At each frame boundary the buffer is copied into the two output slots. A channel map picks which collected sample goes into which slot, and a channel-select field sets how many samples make up one frame. If the buffer is not complete at a frame boundary, that frame is sent as silence.

Each half frame (one slot) is `SLOT_W` bit clocks long, 32 by default. A whole frame is `2*SLOT_W` bit clocks. Data always changes when the uninverted bit clock falls, so a receiver can sample on the rising edge.

Top module: `i2s_serial_tx`

## Requirements
- R1: While any one of `cfg_glb_en`, `cfg_tx_en` or `cfg_line_en` is low, and after reset:
  - `sdo` is 0 and `s_ready` is 0.
  - The sample buffer is emptied.
  - In master mode `bclk_out` equals `cfg_bclk_inv` and `lrck_out` equals `cfg_lrck_inv`.
- R2: In master mode the uninverted bit clock toggles once for each cycle with `bclk_tick` high, and only then. A frame lasts `2*SLOT_W` bit-clock periods.
- R3: With `cfg_fmt`=0 (I2S), the uninverted frame clock is low for slot 0 (left). It changes one bit clock before the MSB of each slot. The 16 data bits follow MSB first, and the remaining slot bits are 0.
- R4: With `cfg_fmt`=1 (left-justified), the uninverted frame clock is high for slot 0. The MSB is driven on the same falling edge as the frame clock change. The bits after the LSB are 0. A value of 3 behaves as 1.
- R5: With `cfg_fmt`=2 (right-justified), the frame clock is the same as for left-justified. The LSB falls on the last bit clock of each slot, and the leading bits of the slot are 0.
- R6: `cfg_bclk_inv`=1 inverts the bit-clock pin, both the driven one and the sensed one. It does not affect data timing relative to the uninverted clock.
- R7: `cfg_lrck_inv`=1 inverts the frame-clock pin, both the driven one and the sensed one. It is independent of R6.
- R8: `sdo` changes only in the cycle where the uninverted bit clock falls.
- R9: With `cfg_slave`=1:
  - `bclk_out` and `lrck_out` are held at 0.
  - The block counts falling edges of `ext_bclk` and starts a frame when `ext_lrck` enters slot 0.
  - Until that first entry is seen, it sends nothing.
- R10: Output slot n (n = 0 or 1) carries the collected sample whose index is in `cfg_chan_map[4n+3:4n]`. An index at or above the active channel count gives 0. The identity map is 8'h10.
- R11: `cfg_chan_sel`=0 makes each frame consume one sample (index 0). Any non-zero value makes each frame consume two samples (index 0 first).
- R12: At a frame boundary where fewer samples than the channel count have been collected, both slots of that frame are 0. The collected samples are kept for the next frame.
- R13: `s_ready` is high only while the block is enabled and the buffer holds fewer samples than the channel count. Samples are accepted in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_glb_en | input | 1 | Global enable |
| cfg_tx_en | input | 1 | Transmit enable |
| cfg_line_en | input | 1 | Enable for serial line 0 |
| cfg_slave | input | 1 | 0: drive clocks, 1: follow external clocks |
| cfg_fmt | input | 2 | Frame format: 0 I2S, 1 left-justified, 2 right-justified |
| cfg_bclk_inv | input | 1 | Bit-clock pin inversion |
| cfg_lrck_inv | input | 1 | Frame-clock pin inversion |
| cfg_chan_sel | input | 3 | Active channels minus one |
| cfg_chan_map | input | 8 | Sample index for slot 0 (bits 3:0) and slot 1 (bits 7:4) |
| bclk_tick | input | 1 | Half-bit-period enable from the divider (master mode) |
| ext_bclk | input | 1 | External bit clock (slave mode) |
| ext_lrck | input | 1 | External frame clock (slave mode) |
| s_valid | input | 1 | Sample valid |
| s_data | input | DATA_W | Sample value |
| s_ready | output | 1 | Sample accepted when high together with s_valid |
| sdo | output | 1 | Serial data line 0 |
| bclk_out | output | 1 | Generated bit clock |
| lrck_out | output | 1 | Generated frame clock |

## Verification
The embedded properties rest on three assumptions:
- The format, inversion, role, channel-select and map fields change only while the block is disabled. Otherwise a data or clock pin could move without a bit-clock fall.
- In slave mode the external clocks change slowly compared with `clk`, so every external edge is seen.
- `s_data` is stable for as long as `s_valid` is offered.

The stimulus keeps to these assumptions as follows. Every configuration change is made inside a window where `cfg_glb_en` is low. The external clock generator toggles only every other system cycle. New data is presented only after the previous sample has been accepted.

// File: rtl/i2s_serial_tx.sv
module i2s_serial_tx #(
  parameter int DATA_W = 16,
  parameter int SLOT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_glb_en,
  input  logic              cfg_tx_en,
  input  logic              cfg_line_en,
  input  logic              cfg_slave,
  input  logic [1:0]        cfg_fmt,
  input  logic              cfg_bclk_inv,
  input  logic              cfg_lrck_inv,
  input  logic [2:0]        cfg_chan_sel,
  input  logic [7:0]        cfg_chan_map,
  input  logic              bclk_tick,
  input  logic              ext_bclk,
  input  logic              ext_lrck,
  input  logic              s_valid,
  input  logic [DATA_W-1:0] s_data,
  output logic              s_ready,
  output logic              sdo,
  output logic              bclk_out,
  output logic              lrck_out
);

  localparam int FRAME = 2 * SLOT_W;
  localparam int CW = $clog2(FRAME);
  localparam int DI = $clog2(DATA_W);
  localparam logic [CW-1:0] LAST = CW'(FRAME - 1);
  localparam logic [CW-1:0] SLOT = CW'(SLOT_W);
  localparam logic [CW-1:0] RJ_OFF = CW'(SLOT_W - DATA_W);

  logic active, is_i2s, is_rj;
  logic [1:0] need;
  assign active = cfg_glb_en & cfg_tx_en & cfg_line_en;
  assign is_i2s = (cfg_fmt == 2'd0);
  assign is_rj  = (cfg_fmt == 2'd2);
  assign need   = (cfg_chan_sel != 3'd0) ? 2'd2 : 2'd1;

  logic bck, bq, lprev, synced;
  logic [CW-1:0] pos, pos_inc, pos_nx;
  logic [1:0] fill;
  logic [DATA_W-1:0] hold0, hold1, frm0, frm1;

  logic nb, nl, left_in, rise_left, fall, latch, full;
  assign nb        = ext_bclk ^ cfg_bclk_inv;
  assign nl        = ext_lrck ^ cfg_lrck_inv;
  assign left_in   = is_i2s ? ~nl : nl;
  assign rise_left = left_in & ~lprev;
  assign fall      = cfg_slave ? (bq & ~nb) : (bclk_tick & bck);
  assign pos_inc   = (pos == LAST) ? '0 : pos + 1'b1;

  always_comb begin
    if (!cfg_slave)     pos_nx = pos_inc;
    else if (rise_left) pos_nx = is_i2s ? LAST : '0;
    else if (synced)    pos_nx = pos_inc;
    else                pos_nx = LAST;
  end

  assign full    = (fill == need);
  assign latch   = fall && (pos_nx == '0);
  assign s_ready = active && (fill < need);

  logic [3:0] idx0, idx1;
  logic [DATA_W-1:0] pick0, pick1;
  assign idx0  = cfg_chan_map[3:0];
  assign idx1  = cfg_chan_map[7:4];
  assign pick0 = (idx0 < {2'b00, need}) ? (idx0[0] ? hold1 : hold0) : '0;
  assign pick1 = (idx1 < {2'b00, need}) ? (idx1[0] ? hold1 : hold0) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bck <= 1'b0; bq <= 1'b0; lprev <= 1'b1; synced <= 1'b0;
      pos <= LAST; fill <= '0;
      hold0 <= '0; hold1 <= '0; frm0 <= '0; frm1 <= '0;
    end else if (!active) begin
      bck <= 1'b0; bq <= nb; lprev <= 1'b1; synced <= 1'b0;
      pos <= LAST; fill <= '0;
      hold0 <= '0; hold1 <= '0; frm0 <= '0; frm1 <= '0;
    end else begin
      bq <= nb;
      if (!cfg_slave && bclk_tick) bck <= ~bck;
      if (fall) begin
        pos <= pos_nx;
        if (cfg_slave) begin
          lprev <= left_in;
          if (rise_left) synced <= 1'b1;
        end
      end
      if (latch) begin
        frm0 <= full ? pick0 : '0;
        frm1 <= full ? pick1 : '0;
      end
      if (latch && full) begin
        fill <= '0;
      end else if (s_valid && s_ready) begin
        if (fill == 2'd0) hold0 <= s_data;
        else              hold1 <= s_data;
        fill <= fill + 1'b1;
      end
    end
  end

  logic half, in_win;
  logic [CW-1:0] kpos, koff, krel;
  logic [DI-1:0] bit_sel;
  assign half    = (pos >= SLOT);
  assign kpos    = half ? pos - SLOT : pos;
  assign koff    = is_rj ? RJ_OFF : '0;
  assign krel    = kpos - koff;
  assign in_win  = (kpos >= koff) && (krel < CW'(DATA_W));
  assign bit_sel = DI'(DATA_W - 1) - krel[DI-1:0];
  assign sdo     = in_win & (half ? frm1[bit_sel] : frm0[bit_sel]);

  logic lr_norm;
  assign lr_norm  = is_i2s ? (pos_inc >= SLOT) : (pos < SLOT);
  assign bclk_out = cfg_slave ? 1'b0 : (bck ^ cfg_bclk_inv);
  assign lrck_out = cfg_slave ? 1'b0 : (lr_norm ^ cfg_lrck_inv);

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !sdo); // R1
  AST_BCLK_TICK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !cfg_slave && !bclk_tick) |=> $stable(bck)); // R2
  AST_LRCK_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_slave && active && $past(active) && !$stable(lrck_out)) |-> $fell(bck)); // R3
  AST_SDO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && !$stable(sdo)) |-> $past(fall)); // R8
  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && (fill == need - 2'd1)) |=> !s_ready); // R13

endmodule

// File: tb/i2s_serial_tx_bench.sv
module i2s_serial_tx_bench;
  localparam int SLOT = 32;
  localparam int FRAME = 64;

  logic clk = 0, rst_n = 0;
  logic cfg_glb_en = 0, cfg_tx_en = 1, cfg_line_en = 1, cfg_slave = 0;
  logic [1:0] cfg_fmt = 0;
  logic cfg_bclk_inv = 0, cfg_lrck_inv = 0;
  logic [2:0] cfg_chan_sel = 3'd1;
  logic [7:0] cfg_chan_map = 8'h10;
  logic bclk_tick = 0, ext_bclk = 0, ext_lrck = 0, s_valid = 0;
  logic [15:0] s_data = 0;
  logic s_ready, sdo, bclk_out, lrck_out;

  i2s_serial_tx u_i2s_serial_tx (
    .clk(clk), .rst_n(rst_n), .cfg_glb_en(cfg_glb_en), .cfg_tx_en(cfg_tx_en),
    .cfg_line_en(cfg_line_en), .cfg_slave(cfg_slave), .cfg_fmt(cfg_fmt),
    .cfg_bclk_inv(cfg_bclk_inv), .cfg_lrck_inv(cfg_lrck_inv),
    .cfg_chan_sel(cfg_chan_sel), .cfg_chan_map(cfg_chan_map),
    .bclk_tick(bclk_tick), .ext_bclk(ext_bclk), .ext_lrck(ext_lrck),
    .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready), .sdo(sdo),
    .bclk_out(bclk_out), .lrck_out(lrck_out));

  always #5 clk = ~clk;

  int tests = 0, fails = 0;
  string cur_req = "R1";
  bit chk_on = 0;
  int tick_en = 0, ext_en = 0, src_mode = 0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // stimulus generators
  int cyc = 0, seq = 0, ext_p = 40;
  bit eb = 0, m_acc = 0;
  always @(negedge clk) begin
    cyc++;
    bclk_tick = (tick_en != 0) && (cyc % 2 == 0);
    if (ext_en != 0 && cyc % 2 == 0) begin
      if (eb) ext_p = (ext_p + 1) % FRAME;
      eb = !eb;
    end
    ext_bclk = eb ^ cfg_bclk_inv;
    ext_lrck = ((cfg_fmt == 0) ? (((ext_p + 1) % FRAME) >= SLOT) : (ext_p < SLOT)) ^ cfg_lrck_inv;
    if (m_acc) seq++;
    s_data = 16'((seq * 40503 + 4660) & 16'hffff);
    case (src_mode)
      0: s_valid = 0;
      1: s_valid = 1;
      default: s_valid = (cyc % 300) < 2;
    endcase
  end

  // behavioural reference model
  int q[$];
  int m_pos = FRAME - 1, fr0 = 0, fr1 = 0, need_m = 2, old_sz = 0, newp = 0;
  bit m_bck = 0, m_bq = 0, m_lprev = 1, m_sync = 0, act_m, nbm, nlm, lfm, fallm, risem;

  function automatic int pickm(input int s);
    int idx;
    idx = (cfg_chan_map >> (4 * s)) & 15;
    if (idx < need_m && idx < q.size()) return q[idx];
    return 0;
  endfunction

  always @(posedge clk) begin
    act_m = cfg_glb_en && cfg_tx_en && cfg_line_en;
    nbm = ext_bclk ^ cfg_bclk_inv;
    nlm = ext_lrck ^ cfg_lrck_inv;
    need_m = (cfg_chan_sel == 0) ? 1 : 2;
    m_acc = 0;
    if (!rst_n || !act_m) begin
      m_pos = FRAME - 1; m_bck = 0; m_bq = rst_n ? nbm : 1'b0;
      q.delete(); fr0 = 0; fr1 = 0; m_sync = 0; m_lprev = 1;
    end else begin
      old_sz = q.size();
      fallm = cfg_slave ? (m_bq && !nbm) : (bclk_tick && m_bck);
      if (fallm) begin
        lfm = (cfg_fmt == 0) ? !nlm : nlm;
        risem = lfm && !m_lprev;
        if (!cfg_slave) newp = (m_pos + 1) % FRAME;
        else begin
          if (risem) newp = (cfg_fmt == 0) ? FRAME - 1 : 0;
          else if (m_sync) newp = (m_pos + 1) % FRAME;
          else newp = FRAME - 1;
          m_lprev = lfm;
          if (risem) m_sync = 1;
        end
        m_pos = newp;
        if (newp == 0) begin
          if (old_sz == need_m) begin
            fr0 = pickm(0); fr1 = pickm(1); q.delete();
          end else begin
            fr0 = 0; fr1 = 0;
          end
        end
      end
      if (old_sz < need_m && s_valid) begin
        q.push_back(int'(s_data)); m_acc = 1;
      end
      if (!cfg_slave && bclk_tick) m_bck = !m_bck;
      m_bq = nbm;
    end
  end

  function automatic bit exp_bit();
    int half, k, off;
    half = m_pos / SLOT; k = m_pos % SLOT;
    off = (cfg_fmt == 2) ? SLOT - 16 : 0;
    if (k >= off && k < off + 16) return 1'(((half != 0 ? fr1 : fr0) >> (15 - (k - off))) & 1);
    return 0;
  endfunction

  // per-cycle comparison
  int n_bchg = 0, n_lchg = 0, n_ones = 0;
  bit p_sdo = 0, p_bclk = 0, p_lrck = 0, p_nb = 0;
  bit e_sdo, e_bclk, e_lrck, e_rdy, n_now;
  always @(posedge clk) begin
    #2;
    if (chk_on) begin
      e_sdo = exp_bit();
      e_bclk = cfg_slave ? 1'b0 : (m_bck ^ cfg_bclk_inv);
      e_lrck = cfg_slave ? 1'b0 : (((cfg_fmt == 0) ? (((m_pos + 1) % FRAME) >= SLOT) : (m_pos < SLOT)) ^ cfg_lrck_inv);
      e_rdy = act_m && (q.size() < need_m);
      check(sdo === e_sdo, cur_req, "sdo", int'(sdo), int'(e_sdo));
      check(bclk_out === e_bclk, cur_req, "bclk_out", int'(bclk_out), int'(e_bclk));
      check(lrck_out === e_lrck, cur_req, "lrck_out", int'(lrck_out), int'(e_lrck));
      check(s_ready === e_rdy, cur_req, "s_ready", int'(s_ready), int'(e_rdy));
      n_now = bclk_out ^ cfg_bclk_inv;
      if (!cfg_slave && act_m && sdo !== p_sdo)
        check(p_nb && !n_now, "R8", "sdo change without bclk fall", int'(n_now), 0);
      if (bclk_out !== p_bclk) n_bchg++;
      if (lrck_out !== p_lrck) n_lchg++;
      if (sdo) n_ones++;
      p_sdo = sdo; p_bclk = bclk_out; p_lrck = lrck_out; p_nb = n_now;
    end
  end

  task automatic run_case(input string req, input int fmt, input bit binv, input bit linv,
                          input bit slave, input int chsel, input int map, input int src, input int ncyc);
    @(negedge clk);
    cfg_glb_en = 0;
    repeat (4) @(negedge clk);
    cur_req = req;
    cfg_fmt = 2'(fmt); cfg_bclk_inv = binv; cfg_lrck_inv = linv; cfg_slave = slave;
    cfg_chan_sel = 3'(chsel); cfg_chan_map = 8'(map);
    src_mode = src; tick_en = slave ? 0 : 1; ext_en = slave ? 1 : 0;
    repeat (2) @(negedge clk);
    cfg_glb_en = 1;
    repeat (ncyc) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  int b0, l0, o0;
  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    chk_on = 1;
    @(negedge clk);
    // R1: reset and disabled state
    check(sdo === 0, "R1", "sdo idle", int'(sdo), 0);
    check(s_ready === 0, "R1", "s_ready idle", int'(s_ready), 0);
    check(bclk_out === 0, "R1", "bclk_out idle", int'(bclk_out), 0);
    check(lrck_out === 0, "R1", "lrck_out idle", int'(lrck_out), 0);
    cfg_bclk_inv = 1; cfg_lrck_inv = 1;
    @(negedge clk);
    check(bclk_out === 1, "R1", "bclk_out idle inverted", int'(bclk_out), 1);
    check(lrck_out === 1, "R1", "lrck_out idle inverted", int'(lrck_out), 1);

    // R3 with R2 frame length check
    run_case("R3", 0, 0, 0, 0, 1, 8'h10, 1, 700);
    b0 = n_bchg; l0 = n_lchg;
    repeat (256) @(negedge clk);
    check(n_bchg - b0 == 128, "R2", "bclk toggles per frame", n_bchg - b0, 128);
    check(n_lchg - l0 == 2, "R2", "lrck toggles per frame", n_lchg - l0, 2);
    run_case("R4", 1, 0, 0, 0, 1, 8'h10, 1, 1100);
    run_case("R4", 3, 0, 0, 0, 1, 8'h10, 1, 800);
    run_case("R5", 2, 0, 0, 0, 1, 8'h10, 1, 1100);
    run_case("R6", 0, 1, 0, 0, 1, 8'h10, 1, 800);
    run_case("R7", 1, 0, 1, 0, 1, 8'h10, 1, 800);
    run_case("R6", 2, 1, 1, 0, 1, 8'h10, 1, 800);
    run_case("R10", 0, 0, 0, 0, 1, 8'h01, 1, 900);
    run_case("R10", 1, 0, 0, 0, 1, 8'h50, 1, 900);
    run_case("R11", 0, 0, 0, 0, 0, 8'h10, 1, 900);
    run_case("R11", 1, 0, 0, 0, 0, 8'h00, 1, 900);
    run_case("R12", 0, 0, 0, 0, 1, 8'h10, 2, 2000);

    // R12: no samples at all gives a silent line while ready stays up
    run_case("R12", 1, 0, 0, 0, 1, 8'h10, 0, 20);
    o0 = n_ones;
    repeat (800) @(negedge clk);
    check(n_ones == o0, "R12", "ones on sdo without samples", n_ones - o0, 0);
    check(s_ready === 1, "R13", "s_ready with empty buffer", int'(s_ready), 1);

    run_case("R9", 0, 1, 1, 1, 1, 8'h10, 1, 1500);
    run_case("R9", 1, 0, 0, 1, 1, 8'h10, 1, 1500);
    run_case("R9", 2, 0, 1, 1, 1, 8'h01, 1, 1500);

    // R1 / R13: dropping an enable mid-stream silences the line and blocks input
    run_case("R13", 0, 0, 0, 0, 1, 8'h10, 1, 600);
    cfg_tx_en = 0;
    @(negedge clk);
    check(s_ready === 0, "R13", "s_ready after tx disable", int'(s_ready), 0);
    check(sdo === 0, "R1", "sdo after tx disable", int'(sdo), 0);
    cfg_tx_en = 1;
    repeat (500) @(negedge clk);
    cfg_line_en = 0;
    @(negedge clk);
    check(s_ready === 0, "R1", "s_ready after line disable", int'(s_ready), 0);
    check(sdo === 0, "R1", "sdo after line disable", int'(sdo), 0);
    cfg_line_en = 1;
    repeat (300) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule